// File: doc/BRIEF.md
# Grouped-block refill engine

This engine completes a data-cache miss once a group size for the miss has been chosen. From the missed block address and a 2-bit group code it forms one naturally aligned region of 1, 2, 4 or 8 base blocks, and it issues a single contiguous request for that region to the next memory level. It then takes the returned data one base block per beat and stores each base block in the direct-mapped set that its own address selects, as if each one were a separate miss. Each written line gets its tag, a valid bit and the group code of the fetch that brought it in.

Before each base block is written, the engine reads the target set. If the line already holds that same block, the fetched copy is dropped. If the line holds a different dirty block, the engine raises a write-back request for that victim and waits for it to be acknowledged before it overwrites the line. Clean or empty lines are overwritten at once. One cycle after the last base block has been stored or dropped, the engine pulses a completion signal and becomes ready for the next miss.

The controller has six states. IDLE waits for a miss. REQ holds the region request until the next level takes it. SLOT takes one beat and writes or drops it. EVICT holds the write-back request. FILL writes a block that was held back during an eviction. DONE pulses completion. The transitions are: IDLE to REQ on an accepted miss; REQ to SLOT when the request is taken; SLOT to EVICT on a dirty victim; SLOT to SLOT or DONE after a write or a drop; EVICT to FILL on acknowledge; FILL to SLOT or DONE; DONE to IDLE.

Top module: `blkgrp_refill`

## Requirements
- R1: After reset, and whenever no miss is in progress, miss_ready is 1 and req_valid, arr_we, wb_req and done are all 0.
- R2: For a miss with block address A and group code g, the request is for 2^g blocks (code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8). Its start address is A with the low g bits cleared. req_valid, req_addr and req_cnt hold steady until req_ready is seen.
- R3: Returned beats are stored in ascending block order. The beat for block address B is written to the set given by the low index bits of B, with the tag given by the remaining high bits and with the beat's data. With no eviction needed, the write happens in the same cycle the beat is taken.
- R4: Every line written by a refill carries, in arr_gsz, the group code of that refill's miss.
- R5: A beat whose block is already resident (the set is valid with an equal tag) is taken and discarded: no write happens to that set, and the resident data is unchanged.
- R6: If the target set holds a valid, dirty line with another tag, wb_req is raised with that set's index and the victim's tag. wb_req holds until wb_ack, and arr_we stays 0 throughout. The held block is written in the cycle after the acknowledge. A valid clean line with another tag is overwritten without a write-back.
- R7: done is a single-cycle pulse in the cycle after the last base block is written or discarded. miss_ready is 1 in the following cycle.
- R8: miss_valid is ignored while a miss is in progress: no second request is issued and no extra line is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss is offered |
| miss_ready | output | 1 | Engine is idle and takes a miss |
| miss_addr | input | ADDR_W | Missed block address |
| miss_gsz | input | GSZ_W | Chosen group code (length is 2^code) |
| req_valid | output | 1 | Region request to the next level |
| req_ready | input | 1 | Next level takes the request |
| req_addr | output | ADDR_W | Aligned first block of the region |
| req_cnt | output | CNT_W | Number of base blocks requested |
| rd_valid | input | 1 | Returned beat present |
| rd_ready | output | 1 | Engine takes a beat |
| rd_data | input | DATA_W | One base block of data |
| arr_lk_idx | output | IDX_W | Set probed for the current block |
| arr_lk_valid | input | 1 | Probed line is valid |
| arr_lk_dirty | input | 1 | Probed line is dirty |
| arr_lk_tag | input | TAG_W | Probed line's tag |
| arr_we | output | 1 | Write one line |
| arr_idx | output | IDX_W | Set written |
| arr_tag | output | TAG_W | Tag written |
| arr_gsz | output | GSZ_W | Group code written |
| arr_data | output | DATA_W | Data written |
| wb_req | output | 1 | Write-back of a dirty victim |
| wb_ack | input | 1 | Write-back taken |
| wb_idx | output | IDX_W | Victim set |
| wb_tag | output | TAG_W | Victim tag |
| done | output | 1 | Refill complete pulse |

## Verification
The bench builds the engine with 4-byte base blocks (32-bit data), a 12-bit block address and 256 sets, which leaves a 4-bit tag. The narrow data keeps every beat easy to compare, and the short tag makes it easy to preload sets with equal or different tags. The full set count and the 2-bit group code keep eight-block regions and their alignment inside the index space. Different runs place resident lines, dirty victims and clean victims at chosen offsets inside a region.

// File: rtl/blkgrp_refill_pkg.sv
package blkgrp_refill_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_SLOT  = 3'd2,
        ST_EVICT = 3'd3,
        ST_FILL  = 3'd4,
        ST_DONE  = 3'd5
    } refill_state_t;

endpackage

// File: rtl/blkgrp_window.sv
module blkgrp_window #(
    parameter int ADDR_W = 26,
    parameter int IDX_W  = 8,
    parameter int GSZ_W  = 2,
    parameter int CNT_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ADDR_W-1:0]   miss_addr,
    input  logic [GSZ_W-1:0]    miss_gsz,
    input  logic                step,
    output logic [ADDR_W-1:0]   base_addr,
    output logic [CNT_W-1:0]    blk_cnt,
    output logic [GSZ_W-1:0]    gsz_q,
    output logic [IDX_W-1:0]    cur_idx,
    output logic [ADDR_W-IDX_W-1:0] cur_tag,
    output logic                last
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] base_q;
    logic [GSZ_W-1:0]  gsz_r;
    logic [CNT_W-1:0]  off_q;
    logic [CNT_W-1:0]  in_cnt;
    logic [ADDR_W-1:0] align_mask;
    logic [ADDR_W-1:0] cur_addr;

    assign in_cnt     = CNT_W'(1) << miss_gsz;
    assign align_mask = ~(ADDR_W'(in_cnt) - ADDR_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            gsz_r  <= '0;
            off_q  <= '0;
        end else if (load) begin
            base_q <= miss_addr & align_mask;
            gsz_r  <= miss_gsz;
            off_q  <= '0;
        end else if (step) begin
            off_q  <= off_q + CNT_W'(1);
        end
    end

    assign base_addr = base_q;
    assign gsz_q     = gsz_r;
    assign blk_cnt   = CNT_W'(1) << gsz_r;
    assign cur_addr  = base_q + ADDR_W'(off_q);
    assign cur_idx   = cur_addr[IDX_W-1:0];
    assign cur_tag   = cur_addr[ADDR_W-1:IDX_W];
    assign last      = (off_q == blk_cnt - CNT_W'(1));

    if (TAG_W < 1) begin : g_bad_width
        initial $error("address must be wider than the set index");
    end
endmodule

// File: rtl/blkgrp_fsm.sv
module blkgrp_fsm
    import blkgrp_refill_pkg::*;
#(
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic              req_ready,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              lk_hit,
    input  logic              lk_dirty_victim,
    input  logic              wb_ack,
    input  logic              last,
    output logic              load,
    output logic              step,
    output logic              miss_ready,
    output logic              req_valid,
    output logic              rd_ready,
    output logic              we,
    output logic [DATA_W-1:0] wdata,
    output logic              wb_req,
    output logic              done
);
    refill_state_t state_q, state_d;
    logic [DATA_W-1:0] hold_q;
    logic take_beat;

    assign take_beat = (state_q == ST_SLOT) && rd_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                  hold_q <= '0;
        else if (take_beat && !lk_hit && lk_dirty_victim) hold_q <= rd_data;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (miss_valid) state_d = ST_REQ;
            ST_REQ:   if (req_ready)  state_d = ST_SLOT;
            ST_SLOT: begin
                if (rd_valid) begin
                    if (!lk_hit && lk_dirty_victim) state_d = ST_EVICT;
                    else if (last)                  state_d = ST_DONE;
                end
            end
            ST_EVICT: if (wb_ack) state_d = ST_FILL;
            ST_FILL:  state_d = last ? ST_DONE : ST_SLOT;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load       = 1'b0;
        step       = 1'b0;
        miss_ready = 1'b0;
        req_valid  = 1'b0;
        rd_ready   = 1'b0;
        we         = 1'b0;
        wdata      = rd_data;
        wb_req     = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                miss_ready = 1'b1;
                load       = miss_valid;
            end
            ST_REQ:   req_valid = 1'b1;
            ST_SLOT: begin
                rd_ready = 1'b1;
                if (rd_valid) begin
                    if (lk_hit) begin
                        step = 1'b1;
                    end else if (!lk_dirty_victim) begin
                        step = 1'b1;
                        we   = 1'b1;
                    end
                end
            end
            ST_EVICT: wb_req = 1'b1;
            ST_FILL: begin
                we    = 1'b1;
                wdata = hold_q;
                step  = 1'b1;
            end
            ST_DONE:  done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/blkgrp_refill.sv
module blkgrp_refill #(
    parameter int ADDR_W      = 26,
    parameter int SET_COUNT   = 256,
    parameter int BLOCK_BYTES = 32,
    parameter int GSZ_W       = 2,
    localparam int DATA_W     = BLOCK_BYTES * 8,
    localparam int IDX_W      = $clog2(SET_COUNT),
    localparam int TAG_W      = ADDR_W - IDX_W,
    localparam int MAX_GROUP  = 1 << ((1 << GSZ_W) - 1),
    localparam int CNT_W      = $clog2(MAX_GROUP) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [GSZ_W-1:0]  miss_gsz,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [CNT_W-1:0]  req_cnt,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  arr_lk_idx,
    input  logic              arr_lk_valid,
    input  logic              arr_lk_dirty,
    input  logic [TAG_W-1:0]  arr_lk_tag,
    output logic              arr_we,
    output logic [IDX_W-1:0]  arr_idx,
    output logic [TAG_W-1:0]  arr_tag,
    output logic [GSZ_W-1:0]  arr_gsz,
    output logic [DATA_W-1:0] arr_data,
    output logic              wb_req,
    input  logic              wb_ack,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [TAG_W-1:0]  wb_tag,
    output logic              done
);
    logic             load, step, last;
    logic [IDX_W-1:0] cur_idx;
    logic [TAG_W-1:0] cur_tag;
    logic [GSZ_W-1:0] gsz_q;
    logic             lk_hit, lk_dirty_victim;

    blkgrp_window #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .GSZ_W(GSZ_W), .CNT_W(CNT_W)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .load(load),
        .miss_addr(miss_addr), .miss_gsz(miss_gsz), .step(step),
        .base_addr(req_addr), .blk_cnt(req_cnt), .gsz_q(gsz_q),
        .cur_idx(cur_idx), .cur_tag(cur_tag), .last(last)
    );

    assign lk_hit          = arr_lk_valid && (arr_lk_tag == cur_tag);
    assign lk_dirty_victim = arr_lk_valid && arr_lk_dirty && !lk_hit;

    blkgrp_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .lk_hit(lk_hit), .lk_dirty_victim(lk_dirty_victim),
        .wb_ack(wb_ack), .last(last), .load(load), .step(step),
        .miss_ready(miss_ready), .req_valid(req_valid), .rd_ready(rd_ready),
        .we(arr_we), .wdata(arr_data), .wb_req(wb_req), .done(done)
    );

    assign arr_lk_idx = cur_idx;
    assign arr_idx    = cur_idx;
    assign arr_tag    = cur_tag;
    assign arr_gsz    = gsz_q;
    assign wb_idx     = cur_idx;
    assign wb_tag     = arr_lk_tag;
endmodule

// File: rtl/blkgrp_refill_chk.sv
module blkgrp_refill_chk #(
    parameter int ADDR_W = 26,
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [CNT_W-1:0]  req_cnt,
    input logic              arr_we,
    input logic              wb_req,
    input logic              wb_ack,
    input logic [IDX_W-1:0]  wb_idx,
    input logic              done
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ready |-> (!req_valid && !arr_we && !wb_req && !done)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_cnt))); // R2

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_addr & (ADDR_W'(req_cnt) - ADDR_W'(1))) == '0)); // R2

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot0(req_cnt) && (req_cnt != '0)); // R2

    AST_NO_WRITE_IN_WB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !arr_we); // R6

    AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_idx))); // R6

    AST_WRITE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_ack) |=> arr_we); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && miss_ready)); // R7
endmodule

bind blkgrp_refill blkgrp_refill_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .miss_ready(miss_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cnt(req_cnt), .arr_we(arr_we), .wb_req(wb_req), .wb_ack(wb_ack),
    .wb_idx(wb_idx), .done(done)
);

// File: tb/test_blkgrp_refill.sv
`timescale 1ns/1ps
module test_blkgrp_refill;
    localparam int AW = 12;
    localparam int IW = 8;
    localparam int TW = AW - IW;
    localparam int DW = 32;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          miss_valid = 0, miss_ready;
    logic [AW-1:0] miss_addr = '0;
    logic [1:0]    miss_gsz = '0;
    logic          req_valid, req_ready = 0;
    logic [AW-1:0] req_addr;
    logic [CW-1:0] req_cnt;
    logic          rd_valid = 0, rd_ready;
    logic [DW-1:0] rd_data = '0;
    logic [IW-1:0] arr_lk_idx;
    logic          arr_lk_valid, arr_lk_dirty;
    logic [TW-1:0] arr_lk_tag;
    logic          arr_we;
    logic [IW-1:0] arr_idx;
    logic [TW-1:0] arr_tag;
    logic [1:0]    arr_gsz;
    logic [DW-1:0] arr_data;
    logic          wb_req, wb_ack = 0;
    logic [IW-1:0] wb_idx;
    logic [TW-1:0] wb_tag;
    logic          done;

    blkgrp_refill #(.ADDR_W(AW), .SET_COUNT(256), .BLOCK_BYTES(4), .GSZ_W(2)) i_blkgrp_refill (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_addr(miss_addr), .miss_gsz(miss_gsz), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_cnt(req_cnt),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .arr_lk_idx(arr_lk_idx), .arr_lk_valid(arr_lk_valid),
        .arr_lk_dirty(arr_lk_dirty), .arr_lk_tag(arr_lk_tag), .arr_we(arr_we),
        .arr_idx(arr_idx), .arr_tag(arr_tag), .arr_gsz(arr_gsz),
        .arr_data(arr_data), .wb_req(wb_req), .wb_ack(wb_ack),
        .wb_idx(wb_idx), .wb_tag(wb_tag), .done(done)
    );

    // cache array model
    logic          m_valid [256];
    logic          m_dirty [256];
    logic [TW-1:0] m_tag   [256];
    logic [1:0]    m_gsz   [256];
    logic [DW-1:0] m_data  [256];
    logic          pl_en = 0, pl_dirty = 0;
    logic [IW-1:0] pl_idx = '0;
    logic [TW-1:0] pl_tag = '0;
    logic [DW-1:0] pl_data = '0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; m_gsz[i] = '0; m_data[i] = '0;
        end
    end

    always @(posedge clk) begin
        if (pl_en) begin
            m_valid[pl_idx] <= 1'b1; m_dirty[pl_idx] <= pl_dirty;
            m_tag[pl_idx] <= pl_tag; m_data[pl_idx] <= pl_data;
        end else if (arr_we) begin
            m_valid[arr_idx] <= 1'b1; m_dirty[arr_idx] <= 1'b0;
            m_tag[arr_idx] <= arr_tag; m_gsz[arr_idx] <= arr_gsz;
            m_data[arr_idx] <= arr_data;
        end
    end

    assign arr_lk_valid = m_valid[arr_lk_idx];
    assign arr_lk_dirty = m_dirty[arr_lk_idx];
    assign arr_lk_tag   = m_tag[arr_lk_idx];

    function automatic logic [DW-1:0] beat_of(input logic [AW-1:0] a);
        return {8'hD7, a, ~a};
    endfunction

    // write-back responder: acknowledge two cycles after request is seen
    int wb_cnt = 0;
    always begin
        @(negedge clk);
        wb_ack = (wb_cnt == 2);
        if (wb_ack) wb_cnt = 0;
        #1;
        if (wb_req && !wb_ack) wb_cnt++;
    end

    // monitor
    int cyc = 0, nwr = 0, nreq = 0, ndone = 0, nwb = 0, overlap = 0;
    int last_acc = 0, last_we = 0, done_cyc = 0, wb_cyc = 0;
    logic [IW-1:0] wr_idx [16];
    logic [TW-1:0] wr_tag [16];
    logic [1:0]    wr_gsz [16];
    logic [DW-1:0] wr_dat [16];
    int            wr_cyc [16];
    logic [IW-1:0] wbi;
    logic [TW-1:0] wbt;
    always begin
        @(negedge clk);
        #1;
        cyc++;
        if (arr_we && nwr < 16) begin
            wr_idx[nwr] = arr_idx; wr_tag[nwr] = arr_tag; wr_gsz[nwr] = arr_gsz;
            wr_dat[nwr] = arr_data; wr_cyc[nwr] = cyc;
        end
        if (arr_we) begin nwr++; last_we = cyc; end
        if (rd_valid && rd_ready) last_acc = cyc;
        if (req_valid && req_ready) nreq++;
        if (done) begin ndone++; done_cyc = cyc; end
        if (wb_req && wb_ack) begin nwb++; wbi = wb_idx; wbt = wb_tag; wb_cyc = cyc; end
        if (wb_req && arr_we) overlap++;
    end

    int n_chk = 0, n_bad = 0;
    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic clear_log();
        nwr = 0; nreq = 0; ndone = 0; nwb = 0; overlap = 0;
    endtask

    task automatic preload(input logic [IW-1:0] idx, input logic [TW-1:0] tag,
                           input logic dirty, input logic [DW-1:0] d);
        @(negedge clk);
        pl_en = 1; pl_idx = idx; pl_tag = tag; pl_dirty = dirty; pl_data = d;
        @(negedge clk);
        pl_en = 0;
    endtask

    // one miss: request handshake, beats, completion
    task automatic run_miss(input logic [AW-1:0] a, input logic [1:0] code, input bit inject);
        logic [AW-1:0] base;
        int cnt, beat, guard;
        bit acc;
        cnt  = 1 << code;
        base = a & ~(AW'(cnt) - AW'(1));
        clear_log();
        @(negedge clk);
        miss_valid = 1; miss_addr = a; miss_gsz = code;
        @(negedge clk);
        miss_valid = inject;
        if (inject) begin miss_addr = 12'hFFF; miss_gsz = 2'd3; end
        #1;
        chk(req_valid === 1'b1, "R2", "req_valid", 32'(req_valid), 1);
        chk(req_addr === base, "R2", "req_addr aligned", 32'(req_addr), 32'(base));
        chk(int'(req_cnt) == cnt, "R2", "req_cnt", 32'(req_cnt), 32'(cnt));
        @(negedge clk);
        #1;
        chk(req_valid === 1'b1 && req_addr === base, "R2", "request held", 32'(req_addr), 32'(base));
        req_ready = 1;
        @(negedge clk);
        req_ready = 0;
        beat = 0; guard = 0;
        while (beat < cnt && guard < 200) begin
            rd_valid = 1; rd_data = beat_of(base + AW'(beat));
            #1;
            acc = rd_ready;
            @(negedge clk);
            if (acc) beat++;
            guard++;
        end
        rd_valid = 0;
        miss_valid = 0;
        guard = 0;
        while (ndone == 0 && guard < 50) begin @(negedge clk); guard++; end
        #2;
        chk(ndone == 1, "R7", "done pulses", 32'(ndone), 1);
        chk(done_cyc == ((last_acc > last_we) ? last_acc : last_we) + 1, "R7",
            "done timing", 32'(done_cyc), 32'(((last_acc > last_we) ? last_acc : last_we) + 1));
        @(negedge clk); #2;
        chk(miss_ready === 1'b1 && done === 1'b0, "R7", "ready after done",
            {30'd0, miss_ready, done}, 32'h2);
    endtask

    task automatic t_reset();
        #2;
        chk(miss_ready === 1'b1, "R1", "miss_ready", 32'(miss_ready), 1);
        chk({req_valid, arr_we, wb_req, done} === 4'b0, "R1", "quiet outputs",
            32'({req_valid, arr_we, wb_req, done}), 0);
    endtask

    task automatic t_single();
        run_miss(12'h123, 2'd0, 0);
        chk(nwr == 1, "R3", "single write count", 32'(nwr), 1);
        chk(wr_idx[0] == 8'h23 && wr_tag[0] == 4'h1, "R3", "single idx/tag",
            {wr_tag[0], wr_idx[0]}, 32'h123);
        chk(wr_dat[0] == beat_of(12'h123), "R3", "single data", wr_dat[0], beat_of(12'h123));
        chk(wr_gsz[0] == 2'd0, "R4", "single group code", 32'(wr_gsz[0]), 0);
    endtask

    task automatic t_eight();
        int bad_i = 0, bad_g = 0, bad_d = 0;
        run_miss(12'h20D, 2'd3, 0);
        chk(nwr == 8, "R3", "eight write count", 32'(nwr), 8);
        for (int i = 0; i < 8; i++) begin
            if (wr_idx[i] != IW'(8'h08 + i) || wr_tag[i] != 4'h2) bad_i++;
            if (wr_dat[i] != beat_of(12'h208 + AW'(i))) bad_d++;
            if (wr_gsz[i] != 2'd3) bad_g++;
        end
        chk(bad_i == 0, "R3", "ascending idx/tag", 32'(bad_i), 0);
        chk(bad_d == 0, "R3", "eight data", 32'(bad_d), 0);
        chk(bad_g == 0, "R4", "eight group code", 32'(bad_g), 0);
        chk(nwb == 0, "R6", "no write-back on empty sets", 32'(nwb), 0);
    endtask

    task automatic t_resident();
        preload(8'hF4, 4'h1, 0, 32'h1111_2222);
        run_miss(12'h1F6, 2'd2, 0);
        chk(nwr == 3, "R5", "resident skipped count", 32'(nwr), 3);
        chk(wr_idx[0] == 8'hF5 && wr_idx[2] == 8'hF7, "R5", "written sets",
            {wr_idx[0], wr_idx[2]}, 32'hF5F7);
        chk(m_data[8'hF4] == 32'h1111_2222, "R5", "resident data kept", m_data[8'hF4], 32'h1111_2222);
        chk(m_gsz[8'hF6] == 2'd2, "R4", "group code of four", 32'(m_gsz[8'hF6]), 2);
    endtask

    task automatic t_victim();
        preload(8'h52, 4'h7, 1, 32'hDEAD_0052);
        preload(8'h53, 4'h9, 0, 32'hBEEF_0053);
        run_miss(12'h353, 2'd1, 0);
        chk(nwb == 1, "R6", "one write-back", 32'(nwb), 1);
        chk(wbi == 8'h52 && wbt == 4'h7, "R6", "victim idx/tag", {wbt, wbi}, 32'h752);
        chk(overlap == 0, "R6", "no write during write-back", 32'(overlap), 0);
        chk(nwr == 2 && wr_idx[0] == 8'h52 && wr_cyc[0] == wb_cyc + 1, "R6",
            "held block written after ack", 32'(wr_cyc[0]), 32'(wb_cyc + 1));
        chk(m_tag[8'h52] == 4'h3 && m_dirty[8'h52] == 0 && m_data[8'h52] == beat_of(12'h352),
            "R6", "victim replaced", m_data[8'h52], beat_of(12'h352));
        chk(m_tag[8'h53] == 4'h3 && m_data[8'h53] == beat_of(12'h353), "R6",
            "clean line overwritten", m_data[8'h53], beat_of(12'h353));
    endtask

    task automatic t_busy_ignore();
        run_miss(12'h0A0, 2'd0, 1);
        chk(nreq == 1, "R8", "single request while busy", 32'(nreq), 1);
        chk(nwr == 1 && wr_idx[0] == 8'hA0, "R8", "only own line written", 32'(nwr), 1);
        chk(m_valid[8'hFF] == 1'b0, "R8", "ignored miss wrote nothing", 32'(m_valid[8'hFF]), 0);
    endtask

    bit finished = 0;
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_single();
        t_eight();
        t_resident();
        t_victim();
        t_busy_ignore();
        t_reset();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule